// File: doc/BRIEF.md
# Timestamped Debug Event Collector

This block gathers single-cycle event strobes from a set of passive probes and turns each one into a fixed-width record: an identifier naming the source and the value of a shared free-running timer. Strobes that arrive together are latched into sticky pending bits. A priority encoder then hands them out one per cycle, lowest code first, so none of them is lost. When the timer wraps, that wrap is itself logged as the most urgent source. This lets the host rebuild absolute time from the short timestamps.

Recording begins only when an event whose identifier equals a run-time trigger code reaches the encoder output. That event becomes the first stored record. Storing then goes on until the record buffer is full, and after that the block stays stopped until reset. A byte-wide valid/ready upload port empties the buffer whenever it holds data, sending each record most significant byte first. Draining can overlap with recording.

Top module: `evt_collector`

## Requirements
- R1: After reset, `up_valid`, `capturing` and `cap_done` are all low.
- R2: Strobes raised in the same cycle on several probes are all kept. They come out as separate records on consecutive cycles in ascending code order. Probe n carries identifier n+1, so a lower probe index wins.
- R3: A strobe on a probe whose earlier event has not yet been emitted merges with it, and only one record results.
- R4: The timestamp of a record is the timer value in the cycle the encoder emits it. The timer counts up by one every clock from 0 after reset. A lone strobe raised while the timer reads t, with nothing else pending, gets timestamp t+1.
- R5: When the timer wraps from all-ones to 0, an event with identifier 0 and timestamp 0 is raised. It takes priority over every probe event pending in the same cycle.
- R6: Before the trigger, emitted events are discarded. The first event whose identifier equals `trig_id` is the first record stored, and `capturing` rises after it.
- R7: When the buffer holds DEPTH records, storing stops for good: `capturing` falls, `cap_done` rises and stays high, and later events are not stored.
- R8: While the buffer is not empty, `up_valid` is high. Each record goes out as (ID_W+TS_W)/8 bytes, with the identifier byte first and most significant byte first. `up_data` holds steady while `up_valid` is high and `up_ready` is low.
- R9: While `capturing` is high and the buffer is not full, new events keep being stored even while the upload port drains records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for collector, timer and upload port |
| rst_n | input | 1 | Asynchronous active-low reset; re-arms the trigger |
| probe_evt | input | N_PROBES | One-cycle event strobe per probe |
| trig_id | input | ID_W | Identifier that starts recording |
| up_ready | input | 1 | Host side accepts the current byte |
| up_data | output | 8 | Current upload byte |
| up_valid | output | 1 | A record byte is offered |
| capturing | output | 1 | Recording has been triggered and is running |
| cap_done | output | 1 | Buffer filled; recording stopped |

## Verification
The hardest situation to reach is a timer wrap that coincides with a pending probe event while the trigger is set to the wrap code itself. The stimulus uses an 8-bit timer. It waits until the timer reads all-ones, pulses probe 0 in that same cycle, and expects the wrap record with timestamp 0 first and the probe record one cycle later. A second difficult case is merging a repeat strobe into a still-pending bit. To produce it, all probes fire at once and the lowest-priority one is pulsed again on the next cycle. A sweep over every non-empty probe mask, with the upload port draining at the same time, covers the ordering rule.

// File: rtl/evt_pkg.sv
package evt_pkg;
   typedef enum logic [1:0] {
      CAP_ARMED = 2'd0,
      CAP_RUN   = 2'd1,
      CAP_DONE  = 2'd2
   } cap_state_e;
endpackage

// File: rtl/evt_timer.sv
module evt_timer #(
   parameter int TS_W = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [TS_W-1:0] count,
   output logic            wrap
);
   localparam logic [TS_W-1:0] TOP = {TS_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end

   assign wrap = (count == TOP);

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(count) == TOP) |-> (count == '0));
endmodule

// File: rtl/evt_prio_enc.sv
module evt_prio_enc #(
   parameter int NIN   = 17,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NIN-1:0]   evt,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);
   logic [NIN-1:0] pending;
   logic [NIN-1:0] grant;
   logic           found;

   always_comb begin
      grant = '0;
      idx   = '0;
      found = 1'b0;
      for (int i = 0; i < NIN; i++) begin
         if (pending[i] && !found) begin
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
            found    = 1'b1;
         end
      end
   end

   assign valid = |pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending <= '0;
      else        pending <= (pending & ~grant) | evt;
   end

   assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $onehot(grant));
   assert_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt & ~pending)) |=> valid);
endmodule

// File: rtl/evt_fifo.sv
module evt_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 512
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         rd_en,
   output logic [W-1:0] rd_data,
   output logic         full,
   output logic         empty
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW:0]  wptr, rptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (wr_en) wptr <= wptr + 1'b1;
         if (rd_en) rptr <= rptr + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wptr[AW-1:0]] <= wr_data;
   end

   assign rd_data = mem[rptr[AW-1:0]];
   assign empty   = (wptr == rptr);
   assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
endmodule

// File: rtl/evt_uploader.sv
module evt_uploader #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] rec,
   input  logic         rec_valid,
   output logic         pop,
   input  logic         up_ready,
   output logic [7:0]   up_data,
   output logic         up_valid
);
   localparam int NB = W / 8;
   localparam int BW = (NB > 1) ? $clog2(NB) : 1;

   assign up_valid = rec_valid;

   generate
      if (NB == 1) begin : g_single
         assign up_data = rec[7:0];
         assign pop     = up_valid && up_ready;
      end else begin : g_multi
         logic [BW-1:0] sel;
         logic          last;

         assign last = (sel == BW'(NB - 1));
         assign pop  = up_valid && up_ready && last;

         always_comb begin
            up_data = '0;
            for (int b = 0; b < NB; b++) begin
               if (sel == BW'(b)) up_data = rec[W-1-8*b -: 8];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     sel <= '0;
            else if (up_valid && up_ready)  sel <= last ? '0 : sel + 1'b1;
         end
      end
   endgenerate

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (up_valid && !up_ready) |=> (up_valid && $stable(up_data)));
endmodule

// File: rtl/evt_collector.sv
module evt_collector #(
   parameter int N_PROBES = 16,
   parameter int ID_W     = 8,
   parameter int TS_W     = 24,
   parameter int DEPTH    = 512
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_PROBES-1:0] probe_evt,
   input  logic [ID_W-1:0]     trig_id,
   input  logic                up_ready,
   output logic [7:0]          up_data,
   output logic                up_valid,
   output logic                capturing,
   output logic                cap_done
);
   import evt_pkg::*;

   localparam int NSRC  = N_PROBES + 1;
   localparam int IDX_W = $clog2(NSRC);
   localparam int REC_W = ID_W + TS_W;

   generate
      if (REC_W % 8 != 0) begin : g_bad_width
         $error("record width must be a whole number of bytes");
      end
      if (N_PROBES < 1 || N_PROBES > 16) begin : g_bad_count
         $error("probe count must be 1 to 16");
      end
      if (IDX_W > ID_W || NSRC > (1 << ID_W)) begin : g_bad_id
         $error("identifier field too narrow");
      end
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
         $error("buffer depth must be a power of two");
      end
   endgenerate

   logic [TS_W-1:0]  tstamp;
   logic             wrap;
   logic             enc_valid;
   logic [IDX_W-1:0] enc_idx;
   logic [ID_W-1:0]  code;
   logic             wr_en, rd_en, full, empty;
   logic [REC_W-1:0] rd_rec;
   cap_state_e       st;

   evt_timer #(.TS_W(TS_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .count(tstamp), .wrap(wrap));

   evt_prio_enc #(.NIN(NSRC), .IDX_W(IDX_W)) u_enc (
      .clk(clk), .rst_n(rst_n), .evt({probe_evt, wrap}),
      .valid(enc_valid), .idx(enc_idx));

   assign code  = ID_W'(enc_idx);
   assign wr_en = enc_valid && !full &&
                  ((st == CAP_RUN) || ((st == CAP_ARMED) && (code == trig_id)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= CAP_ARMED;
      else begin
         case (st)
            CAP_ARMED: if (wr_en) st <= CAP_RUN;
            CAP_RUN:   if (full)  st <= CAP_DONE;
            default:              st <= CAP_DONE;
         endcase
      end
   end

   evt_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data({code, tstamp}),
      .rd_en(rd_en), .rd_data(rd_rec), .full(full), .empty(empty));

   evt_uploader #(.W(REC_W)) u_up (
      .clk(clk), .rst_n(rst_n), .rec(rd_rec), .rec_valid(!empty),
      .pop(rd_en), .up_ready(up_ready), .up_data(up_data), .up_valid(up_valid));

   assign capturing = (st == CAP_RUN);
   assign cap_done  = (st == CAP_DONE);

   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cap_done |=> (cap_done && !capturing));
   assert_start_on_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(capturing) |-> !empty);
endmodule

// File: tb/evt_collector_bench.sv
`timescale 1ns/1ps
module evt_collector_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] probe_evt = '0;
   logic [7:0] trig_id = '0;
   logic       up_ready = 1'b0;
   logic [7:0] up_data;
   logic       up_valid, capturing, cap_done;
   logic [1:0] rdy_mode = 2'd0;
   logic [7:0] tcnt;
   int         checks = 0;
   int         errors = 0;
   logic [7:0] got[$];
   logic [7:0] exp[$];

   always #2 clk = ~clk;

   evt_collector #(.N_PROBES(4), .ID_W(8), .TS_W(8), .DEPTH(8)) u_evt_collector (
      .clk(clk), .rst_n(rst_n), .probe_evt(probe_evt), .trig_id(trig_id),
      .up_ready(up_ready), .up_data(up_data), .up_valid(up_valid),
      .capturing(capturing), .cap_done(cap_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tcnt <= '0;
      else        tcnt <= tcnt + 1'b1;
   end

   always @(negedge clk) begin
      case (rdy_mode)
         2'd0:    up_ready <= 1'b0;
         2'd1:    up_ready <= 1'b1;
         default: up_ready <= ~up_ready;
      endcase
   end

   always @(negedge clk) begin
      #1;
      if (rst_n && up_valid && up_ready) got.push_back(up_data);
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] want);
      checks++;
      if (act !== want) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, want);
      end
   endtask

   task automatic exp_rec(input logic [7:0] id, input logic [7:0] ts);
      exp.push_back(id);
      exp.push_back(ts);
   endtask

   task automatic cmp_stream(input string req);
      int n;
      chk({req, " byte count"}, got.size(), exp.size());
      n = (got.size() < exp.size()) ? got.size() : exp.size();
      for (int i = 0; i < n; i++) chk(req, got[i], exp[i]);
      got.delete();
      exp.delete();
   endtask

   task automatic wait_t(input logic [7:0] v);
      do @(negedge clk); while (tcnt != v);
   endtask

   task automatic pulse(input logic [3:0] m);
      probe_evt = m;
      @(negedge clk);
      probe_evt = '0;
   endtask

   task automatic do_reset(input logic [7:0] trig);
      @(negedge clk);
      rst_n = 1'b0;
      rdy_mode = 2'd0;
      probe_evt = '0;
      trig_id = trig;
      repeat (2) @(negedge clk);
      got.delete();
      exp.delete();
      rst_n = 1'b1;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1: reset state
      do_reset(8'd3);
      @(negedge clk); #1;
      chk("R1 up_valid", up_valid, 0);
      chk("R1 capturing", capturing, 0);
      chk("R1 cap_done", cap_done, 0);

      // Scenario 1: trigger on probe 2 (code 3), fill buffer, then stop (R2 R3 R4 R6 R7 R8)
      wait_t(8'd10); pulse(4'b0001);            // code1 @11, before trigger: dropped (R6)
      wait_t(8'd20);
      probe_evt = 4'hF; @(negedge clk);         // codes 1..4 at 21..24
      probe_evt = 4'h8; @(negedge clk);         // R3: probe3 still pending, merges
      probe_evt = '0;
      exp_rec(8'd3, 8'd23); exp_rec(8'd4, 8'd24);
      wait_t(8'd30); #1;
      chk("R6 capturing after trigger", capturing, 1);
      wait_t(8'd40); pulse(4'b0110);
      exp_rec(8'd2, 8'd41); exp_rec(8'd3, 8'd42);
      wait_t(8'd50); pulse(4'b1111);
      exp_rec(8'd1, 8'd51); exp_rec(8'd2, 8'd52); exp_rec(8'd3, 8'd53); exp_rec(8'd4, 8'd54);
      wait_t(8'd58); #1;
      chk("R7 cap_done", cap_done, 1);
      chk("R7 capturing low", capturing, 0);
      chk("R8 valid while held", up_valid, 1);
      chk("R8 first byte is id", up_data, 8'd3);
      wait_t(8'd60); pulse(4'b0001);            // R7: dropped after stop
      wait_t(8'd70);
      rdy_mode = 2'd2;                          // R8: drain with stalls
      wait_t(8'd120);
      cmp_stream("R7 R8 R2 R4 stream");
      chk("R8 valid low when empty", up_valid, 0);
      wait_t(8'd5);                             // past a timer wrap
      #1;
      chk("R7 no record after stop", got.size(), 0);
      chk("R7 cap_done held", cap_done, 1);

      // Scenario 2: trigger on the wrap code 0 (R5 R6 R9)
      do_reset(8'd0);
      wait_t(8'd250); pulse(4'b1111);           // 251..254, dropped
      wait_t(8'd255); pulse(4'b0001);           // same cycle as wrap
      exp_rec(8'd0, 8'd0); exp_rec(8'd1, 8'd1);
      wait_t(8'd5); pulse(4'b1001);
      exp_rec(8'd1, 8'd6); exp_rec(8'd4, 8'd7);
      wait_t(8'd12); #1;
      chk("R6 capturing on wrap trigger", capturing, 1);
      chk("R9 not done", cap_done, 0);
      chk("R6 nothing uploaded yet", got.size(), 0);
      rdy_mode = 2'd1;
      wait_t(8'd20); pulse(4'b0100);            // R9: stored while draining
      exp_rec(8'd3, 8'd21);
      wait_t(8'd40);
      cmp_stream("R5 R9 stream");

      // Scenario 3: sweep all probe masks with continuous draining (R2 R4 R9)
      do_reset(8'd1);
      rdy_mode = 2'd1;
      wait_t(8'd10); pulse(4'b0001);
      exp_rec(8'd1, 8'd11);
      for (int m = 1; m < 16; m++) begin
         int k;
         logic [7:0] c;
         c = 8'(20 + 10 * (m - 1));
         wait_t(c); pulse(4'(m));
         k = 0;
         for (int i = 0; i < 4; i++) begin
            if (m[i]) begin
               exp_rec(8'(i + 1), 8'(c + 1 + k));
               k++;
            end
         end
      end
      wait_t(8'd200);
      cmp_stream("R2 R4 sweep");
      chk("R9 still capturing", capturing, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule